// File: doc/BRIEF.md
# Registered Sum-of-Products Array Emulator

This block reproduces, one clock at a time, the behaviour of a small fuse-programmed logic device of the 20-pin class. A programmable AND plane of 64 product terms sees 32 input columns. These columns are the true and inverted forms of 16 signals: dedicated inputs, pad inputs and register feedback. The terms feed 8 fixed OR groups, one per output pin. A build-time parameter selects the pin layout. The layouts are eight registered pins, six registered plus two bidirectional, four registered plus four bidirectional, or a purely combinational layout with ten dedicated inputs.

The fuse map sits in a small configuration store. A host erases it, writes it row by row, and may read it back until a security bit is set. In normal use the host first erases the map, then writes the rows it needs, and then lets the array run. Registers clear on the synchronous reset, which stands for the device's power-up clear. A test-mode preload input lets the host force any register state from the pads.

Top module: `pal_array_emu`

## Requirements
- R1: An erase (`cfg_en` and `cfg_erase` high at a clock edge) sets every fuse bit of all 64 rows to 1 (intact) and clears the security bit. A row whose fuses are all intact evaluates to 0, so after an erase every combinational enable is low and every register loads 0.
- R2: A row write (`cfg_we`) takes effect only when `cfg_en` is high at the same edge. With `cfg_en` low the addressed row keeps its old contents. Erase takes priority over a write.
- R3: When the security bit is set (`cfg_en` and `cfg_lock` at an edge), `cfg_rdata` reads as all zeros. Only an erase clears the bit. It has no effect on the array's logic.
- R4: Product term r is the AND of every column c whose fuse bit `map[r][c]` is 1. Column 2s carries signal s and column 2s+1 carries its inverse. Signals 0–7 are `din[7:0]`. Signal 8+k belongs to pin k: the register content for a registered pin, otherwise `pin_i[k]`.
- R5: A registered pin k loads the OR of rows 8k..8k+7 into its register on the rising clock edge. `pin_o[k]` shows the inverted register content.
- R6: Synchronous reset clears every register, so registered pins show 1 on the cycle after reset. Reset wins over preload.
- R7: Registered pins drive (`pin_oe` high) exactly when `oe_n` is low and `preload` is low.
- R8: A non-registered pin k uses row 8k as its own output enable. It drives the inverse of the OR of rows 8k+1..8k+7.
- R9: On a non-registered pin, the pad level `pin_i[k]` enters the array as signal 8+k. In the fully combinational layout, pins 0 and 7 instead take `din[8]` and `din[9]` as signals 8 and 15.
- R10: With `preload` high, each register loads the inverse of its pad level `pin_i[k]` at the clock edge, so the pin then shows the level that was applied. Its output drivers stay off while `preload` is high.
- R11: Registered pins per layout: PAL_R8 all 8, PAL_R6 pins 1–6, PAL_R4 pins 2–5, PAL_L8 none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset (power-up clear) |
| cfg_en | input | 1 | Configuration access enable |
| cfg_erase | input | 1 | Erase whole map to intact, clear security |
| cfg_we | input | 1 | Write `cfg_wdata` into row `cfg_addr` |
| cfg_lock | input | 1 | Set the security bit |
| cfg_addr | input | 6 | Row address for write and readback |
| cfg_wdata | input | 32 | Row fuse data, 1 = intact |
| cfg_rdata | output | 32 | Readback of row `cfg_addr`, zero when secured |
| din | input | 10 | Dedicated inputs (bits 9:8 used only by PAL_L8) |
| oe_n | input | 1 | Shared active-low enable of registered pins |
| preload | input | 1 | Test-mode register preload from pads |
| pin_i | input | 8 | Pad levels seen by the array |
| pin_o | output | 8 | Level each pin drives |
| pin_oe | output | 8 | Per-pin driver enable |

## Verification
Reset and preload can both be active in the same cycle, and each wants to load the registers. The bench raises both together while the pads carry all zeros. A preload alone would therefore set every register, while the reset must clear them. The run is judged by the registered pins reading all ones on the next cycle. A behavioural model of the fuse map and registers is compared with every output on every clock. Directed checks cover count wraparound, secured readback and a held preloaded state.

// File: rtl/pal_emu_pkg.sv
package pal_emu_pkg;

    typedef enum logic [1:0] {
        PAL_R8 = 2'd0,
        PAL_R6 = 2'd1,
        PAL_R4 = 2'd2,
        PAL_L8 = 2'd3
    } pal_variant_e;

    localparam int PAL_PINS          = 8;
    localparam int PAL_TERMS_PER_PIN = 8;
    localparam int PAL_ROWS          = PAL_PINS * PAL_TERMS_PER_PIN;
    localparam int PAL_SIGNALS       = 16;
    localparam int PAL_COLS          = 2 * PAL_SIGNALS;
    localparam int PAL_DIN_W         = 10;
    localparam int PAL_ADDR_W        = $clog2(PAL_ROWS);

    typedef logic [PAL_COLS-1:0] fuse_row_t;
    typedef logic [PAL_PINS-1:0] pin_vec_t;

    typedef struct packed {
        logic level;
        logic drive;
    } pad_t;

    function automatic pin_vec_t reg_pin_mask(pal_variant_e v);
        case (v)
            PAL_R8:  return 8'b1111_1111;
            PAL_R6:  return 8'b0111_1110;
            PAL_R4:  return 8'b0011_1100;
            default: return 8'b0000_0000;
        endcase
    endfunction

    function automatic logic fixed_input_pin(pal_variant_e v, int k);
        return (v == PAL_L8) && ((k == 0) || (k == PAL_PINS - 1));
    endfunction

    function automatic fuse_row_t expand_columns(logic [PAL_SIGNALS-1:0] s);
        fuse_row_t c;
        for (int i = 0; i < PAL_SIGNALS; i++) begin
            c[2*i]   = s[i];
            c[2*i+1] = ~s[i];
        end
        return c;
    endfunction

endpackage

// File: rtl/pal_fuse_store.sv
module pal_fuse_store #(
    parameter int ROWS = 64,
    parameter int COLS = 32,
    parameter int AW   = $clog2(ROWS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_en,
    input  logic                      cfg_erase,
    input  logic                      cfg_we,
    input  logic                      cfg_lock,
    input  logic [AW-1:0]             cfg_addr,
    input  logic [COLS-1:0]           cfg_wdata,
    output logic [COLS-1:0]           cfg_rdata,
    output logic [ROWS-1:0][COLS-1:0] fuse_map
);

    logic [ROWS-1:0][COLS-1:0] map_q;
    logic                      secure_q;

    // Fuses survive the power-up clear, so the store has no reset.
    always_ff @(posedge clk) begin
        if (cfg_en) begin
            if (cfg_erase) begin
                map_q    <= '1;
                secure_q <= 1'b0;
            end else begin
                if (cfg_we) begin
                    map_q[cfg_addr] <= cfg_wdata;
                end
                if (cfg_lock) begin
                    secure_q <= 1'b1;
                end
            end
        end
    end

    assign cfg_rdata = secure_q ? '0 : map_q[cfg_addr];
    assign fuse_map  = map_q;

    // R2
    closed_map_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(map_q));

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (secure_q && !(cfg_en && cfg_erase)) |=> secure_q);

    // R1
    erase_virgin_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_erase) |=> ((map_q == '1) && !secure_q));

endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
    parameter int ROWS = 64,
    parameter int COLS = 32
) (
    input  logic [ROWS-1:0][COLS-1:0] fuse_map,
    input  logic [COLS-1:0]           cols,
    output logic [ROWS-1:0]           terms
);

    // An intact fuse ties its column into the AND; a blown one lets it float high.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign terms[r] = &(cols | ~fuse_map[r]);
    end

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
    import pal_emu_pkg::*;
#(
    parameter bit REGISTERED = 1'b1,
    parameter int TERMS      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             preload,
    input  logic             oe_n,
    input  logic [TERMS-1:0] terms,
    input  logic             pad_in,
    output pad_t             pad,
    output logic             fb
);

    if (REGISTERED) begin : g_reg
        logic state_q;
        logic d_sum;

        assign d_sum = |terms;

        always_ff @(posedge clk) begin
            if (rst) begin
                state_q <= 1'b0;
            end else if (preload) begin
                state_q <= ~pad_in;
            end else begin
                state_q <= d_sum;
            end
        end

        assign pad = pad_t'{level: ~state_q, drive: (!oe_n && !preload)};
        assign fb  = state_q;

        // R6
        reset_clear_chk: assert property (@(posedge clk)
            rst |=> !state_q);

        // R10
        preload_take_chk: assert property (@(posedge clk) disable iff (rst)
            preload |=> (state_q == !$past(pad_in)));

        // R5
        sum_load_chk: assert property (@(posedge clk) disable iff (rst)
            !preload |=> (state_q == $past(d_sum)));
    end else begin : g_comb
        logic unused_cell;

        assign pad = pad_t'{level: ~(|terms[TERMS-1:1]), drive: terms[0]};
        assign fb  = pad_in;
        assign unused_cell = ^{clk, rst, oe_n, preload};
    end

endmodule

// File: rtl/pal_array_emu.sv
module pal_array_emu
    import pal_emu_pkg::*;
#(
    parameter pal_variant_e VARIANT = PAL_R8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_en,
    input  logic                  cfg_erase,
    input  logic                  cfg_we,
    input  logic                  cfg_lock,
    input  logic [PAL_ADDR_W-1:0] cfg_addr,
    input  logic [PAL_COLS-1:0]   cfg_wdata,
    output logic [PAL_COLS-1:0]   cfg_rdata,
    input  logic [PAL_DIN_W-1:0]  din,
    input  logic                  oe_n,
    input  logic                  preload,
    input  logic [PAL_PINS-1:0]   pin_i,
    output logic [PAL_PINS-1:0]   pin_o,
    output logic [PAL_PINS-1:0]   pin_oe
);

    localparam pin_vec_t REG_MASK = reg_pin_mask(VARIANT);

    logic [PAL_ROWS-1:0][PAL_COLS-1:0] fuse_map;
    logic [PAL_ROWS-1:0]               terms;
    logic [PAL_SIGNALS-1:0]            sig;
    fuse_row_t                         cols;
    pin_vec_t                          fb;
    pad_t [PAL_PINS-1:0]               pads;
    logic                              unused_bits;

    pal_fuse_store #(.ROWS(PAL_ROWS), .COLS(PAL_COLS), .AW(PAL_ADDR_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_erase(cfg_erase),
        .cfg_we   (cfg_we),
        .cfg_lock (cfg_lock),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .fuse_map (fuse_map)
    );

    assign sig[PAL_PINS-1:0] = din[PAL_PINS-1:0];
    assign cols = expand_columns(sig);

    pal_and_plane #(.ROWS(PAL_ROWS), .COLS(PAL_COLS)) u_plane (
        .fuse_map(fuse_map),
        .cols    (cols),
        .terms   (terms)
    );

    for (genvar k = 0; k < PAL_PINS; k++) begin : g_pin
        if (fixed_input_pin(VARIANT, k)) begin : g_fixed
            assign sig[PAL_PINS+k] = din[PAL_PINS + ((k == 0) ? 0 : 1)];
        end else begin : g_fed
            assign sig[PAL_PINS+k] = fb[k];
        end

        pal_macrocell #(
            .REGISTERED(REG_MASK[k]),
            .TERMS     (PAL_TERMS_PER_PIN)
        ) u_cell (
            .clk    (clk),
            .rst    (rst),
            .preload(preload),
            .oe_n   (oe_n),
            .terms  (terms[k*PAL_TERMS_PER_PIN +: PAL_TERMS_PER_PIN]),
            .pad_in (pin_i[k]),
            .pad    (pads[k]),
            .fb     (fb[k])
        );

        assign pin_o[k]  = pads[k].level;
        assign pin_oe[k] = pads[k].drive;
    end

    assign unused_bits = ^{din, fb};

    // R7
    shared_off_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> ((pin_oe & REG_MASK) == '0));

    // R7
    shared_on_chk: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && !preload) |-> ((pin_oe & REG_MASK) == REG_MASK));

endmodule

// File: tb/pal_array_emu_test.sv
module pal_array_emu_test;
    import pal_emu_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_en = 1'b0, cfg_erase = 1'b0, cfg_we = 1'b0, cfg_lock = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [9:0]  din = '0;
    logic        oe_n = 1'b1, preload = 1'b0;
    logic [7:0]  pin_i = '0;
    logic [7:0]  pin_o, pin_oe;

    int checks = 0, errors = 0, cnt = 0;
    bit done = 1'b0, armed = 1'b0;

    pal_array_emu #(.VARIANT(PAL_R4)) uut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_erase(cfg_erase),
        .cfg_we(cfg_we), .cfg_lock(cfg_lock), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .din(din),
        .oe_n(oe_n), .preload(preload), .pin_i(pin_i),
        .pin_o(pin_o), .pin_oe(pin_oe)
    );

    always #5 clk = ~clk;

    // Behavioural reference: map, security bit, register contents (R4 layout: pins 2..5)
    localparam bit [7:0] M_REG = 8'b0011_1100;
    bit [31:0] m_map [64];
    bit        m_sec = 1'b0;
    bit [7:0]  m_q = '0;

    function automatic bit [31:0] m_cols();
        bit [31:0] c;
        for (int s = 0; s < 16; s++) begin
            bit v;
            if (s < 8) v = din[s];
            else if (M_REG[s-8]) v = m_q[s-8];
            else v = pin_i[s-8];
            c[2*s]   = v;
            c[2*s+1] = !v;
        end
        return c;
    endfunction

    function automatic bit m_term(int r);
        return ((m_cols() | ~m_map[r]) == 32'hFFFF_FFFF);
    endfunction

    function automatic bit [31:0] lit(int c);
        bit [31:0] r;
        r = '0;
        r[c] = 1'b1;
        return r;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare();
        bit [7:0] eo, eoe;
        for (int k = 0; k < 8; k++) begin
            if (M_REG[k]) begin
                eo[k]  = !m_q[k];
                eoe[k] = !oe_n && !preload;
            end else begin
                bit acc;
                acc = 1'b0;
                for (int j = 1; j < 8; j++) acc |= m_term(8*k + j);
                eo[k]  = !acc;
                eoe[k] = m_term(8*k);
            end
        end
        if (armed) begin
            check(pin_o === eo, "R5/R8 pin_o", pin_o, eo);
            check(pin_oe === eoe, "R7/R8 pin_oe", pin_oe, eoe);
            check(cfg_rdata === (m_sec ? 32'd0 : m_map[cfg_addr]), "R2/R3 readback",
                  cfg_rdata, m_sec ? 32'd0 : m_map[cfg_addr]);
        end
    endtask

    task automatic tick();
        bit [7:0]  nq;
        bit        en, er, we, lk;
        bit [5:0]  a;
        bit [31:0] w;
        nq = m_q;
        for (int k = 0; k < 8; k++) begin
            if (M_REG[k]) begin
                bit acc;
                acc = 1'b0;
                for (int j = 0; j < 8; j++) acc |= m_term(8*k + j);
                nq[k] = rst ? 1'b0 : (preload ? !pin_i[k] : acc);
            end
        end
        en = cfg_en; er = cfg_erase; we = cfg_we; lk = cfg_lock;
        a = cfg_addr; w = cfg_wdata;
        @(posedge clk);
        m_q = nq;
        if (en) begin
            if (er) begin
                for (int r = 0; r < 64; r++) m_map[r] = 32'hFFFF_FFFF;
                m_sec = 1'b0;
            end else begin
                if (we) m_map[a] = w;
                if (lk) m_sec = 1'b1;
            end
        end
        @(negedge clk);
        compare();
    endtask

    task automatic prog(int addr, bit [31:0] data);
        cfg_en = 1'b1; cfg_we = 1'b1; cfg_addr = 6'(addr); cfg_wdata = data;
        tick();
        cfg_en = 1'b0; cfg_we = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        // erase while in reset
        cfg_en = 1'b1; cfg_erase = 1'b1;
        tick();
        cfg_en = 1'b0; cfg_erase = 1'b0; armed = 1'b1;
        cfg_addr = 6'd7;
        tick();
        check(cfg_rdata === 32'hFFFF_FFFF, "R1 erased readback", cfg_rdata, 32'hFFFF_FFFF);
        check(pin_oe === 8'h00, "R1 virgin enables", pin_oe, 8'h00);
        check(pin_o[5:2] === 4'hF, "R6 reset pins high", pin_o[5:2], 4'hF);

        // combinational pins
        prog(0, 32'd0);
        prog(1, lit(2));
        prog(2, lit(9) | lit(10));
        prog(8, lit(4));
        prog(9, lit(20));
        prog(56, lit(6));
        prog(57, lit(28));
        // 4-bit up counter with enable din[0], bit b on pin 2+b
        for (int b = 0; b < 4; b++) begin
            int r;
            bit [31:0] t;
            r = 8 * (2 + b);
            prog(r, lit(20 + 2*b) | lit(1));
            r++;
            for (int j = 0; j < b; j++) begin
                prog(r, lit(20 + 2*b) | lit(21 + 2*j));
                r++;
            end
            t = lit(21 + 2*b) | lit(0);
            for (int j = 0; j < b; j++) t |= lit(20 + 2*j);
            prog(r, t);
        end

        // R2: write without enable is dropped
        cfg_we = 1'b1; cfg_addr = 6'd3; cfg_wdata = 32'h1234_5678;
        tick();
        cfg_we = 1'b0;
        tick();
        check(cfg_rdata === 32'hFFFF_FFFF, "R2 closed write ignored", cfg_rdata, 32'hFFFF_FFFF);

        // count sequence with wraparound
        rst = 1'b0; oe_n = 1'b0;
        tick();
        check(pin_o[5:2] === 4'hF, "R6 held after reset", pin_o[5:2], 4'hF);
        din[0] = 1'b1;
        for (int n = 1; n <= 20; n++) begin
            tick();
            cnt = n % 16;
            check(pin_o[5:2] === ~4'(cnt), "R5 count", pin_o[5:2], ~4'(cnt));
        end
        check(pin_oe[5:2] === 4'hF, "R7 enabled", pin_oe[5:2], 4'hF);
        din[0] = 1'b0;
        oe_n = 1'b1;
        tick();
        check(pin_oe[5:2] === 4'h0, "R7 disabled", pin_oe[5:2], 4'h0);
        check(pin_o[5:2] === ~4'(cnt), "R7 state kept", pin_o[5:2], ~4'(cnt));
        oe_n = 1'b0;

        // R4 / R8: pin0 = ~(din1 | (~din4 & din5))
        din[1] = 1'b0; din[4] = 1'b0; din[5] = 1'b1;
        tick();
        check(pin_o[0] === 1'b0 && pin_oe[0] === 1'b1, "R4 complement column", pin_o[0], 1'b0);
        din[5] = 1'b0;
        tick();
        check(pin_o[0] === 1'b1, "R8 inverted sum", pin_o[0], 1'b1);
        din[1] = 1'b1;
        tick();
        check(pin_o[0] === 1'b0, "R8 true column", pin_o[0], 1'b0);
        din[2] = 1'b0;
        tick();
        check(pin_oe[1] === 1'b0, "R8 term enable off", pin_oe[1], 1'b0);
        din[2] = 1'b1;
        tick();
        check(pin_oe[1] === 1'b1 && pin_o[1] === !cnt[0], "R8 term enable on", pin_o[1], !cnt[0]);

        // R9: pad input path pin6 -> pin7
        din[3] = 1'b1; pin_i[6] = 1'b1;
        tick();
        check(pin_o[7] === 1'b0, "R9 pad feeds array", pin_o[7], 1'b0);
        pin_i[6] = 1'b0;
        tick();
        check(pin_o[7] === 1'b1, "R9 pad low", pin_o[7], 1'b1);
        check(pin_oe === 8'b1011_1111, "R11 layout enables", pin_oe, 8'b1011_1111);

        // R3: security
        cfg_en = 1'b1; cfg_lock = 1'b1;
        tick();
        cfg_en = 1'b0; cfg_lock = 1'b0; cfg_addr = 6'd1;
        tick();
        check(cfg_rdata === 32'd0, "R3 secured readback", cfg_rdata, 32'd0);
        din[0] = 1'b1;
        tick();
        cnt = (cnt + 1) % 16;
        din[0] = 1'b0;
        check(pin_o[5:2] === ~4'(cnt), "R3 logic unaffected", pin_o[5:2], ~4'(cnt));

        // R10: preload
        preload = 1'b1; pin_i[5:2] = 4'b1010;
        tick();
        check(pin_oe[5:2] === 4'h0, "R10 drivers off", pin_oe[5:2], 4'h0);
        check(pin_o[5:2] === 4'b1010, "R10 preloaded", pin_o[5:2], 4'b1010);
        preload = 1'b0;
        for (int n = 0; n < 3; n++) tick();
        check(pin_o[5:2] === 4'b1010, "R10 held", pin_o[5:2], 4'b1010);
        din[0] = 1'b1;
        tick();
        din[0] = 1'b0;
        check(pin_o[5:2] === 4'b1001, "R10 counts on", pin_o[5:2], 4'b1001);

        // reset and preload in the same cycle
        rst = 1'b1; preload = 1'b1; pin_i[5:2] = 4'b0000;
        tick();
        check(pin_o[5:2] === 4'hF, "R6 reset beats preload", pin_o[5:2], 4'hF);
        rst = 1'b0; preload = 1'b0;

        // R1: re-erase clears security and function
        din[0] = 1'b1;
        cfg_en = 1'b1; cfg_erase = 1'b1;
        tick();
        cfg_en = 1'b0; cfg_erase = 1'b0;
        tick();
        check(cfg_rdata === 32'hFFFF_FFFF, "R1 security cleared", cfg_rdata, 32'hFFFF_FFFF);
        check(pin_oe[0] === 1'b0, "R1 virgin enable", pin_oe[0], 1'b0);
        check(pin_o[5:2] === 4'hF, "R1 virgin sum", pin_o[5:2], 4'hF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule